// File: doc/BRIEF.md
# Accumulator Machine Instruction Sequencer

This block is the hardwired control and datapath of a small 16-bit accumulator computer. It holds a word-addressed program and data memory, a program counter, an address register, an instruction register, a data register, the accumulator, a carry flag, an indirect flag and a run flag. A small slot counter is decoded into one-hot timing slots, and every instruction is played out as a fixed script of those slots. The counter goes back to slot 0 when the instruction finishes.

The core fetches and decodes each word and resolves one level of indirection. It then executes the seven memory-operand operations directly: and, add, load, store, jump, call and increment-and-skip. Opcode 7 is passed to an external register-operation unit. The core raises a one-cycle start, shows the low 12 instruction bits, and waits in slot 3 until that unit answers with done. If the unit answers with halt, the core stops for good. The memory is filled through a load port that only writes while reset is held.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is low: PC, slot counter, AC and E read 0, run reads 1, and the load port writes ld_data into word ld_addr on each rising clock with ld_en high.
- R2: The slot counter counts up by one per clock from 0 and returns to 0 after the last slot. The last slot is 4 for store and jump, 5 for and, add, load and call, and 6 for increment-and-skip. The counter never exceeds 6.
- R3: Fetch uses word format bit 15 = indirect, bits 14:12 = opcode, bits 11:0 = address. Each fetched instruction adds one to PC in slot 1.
- R4: With bit 15 set and opcode other than 7, the effective address is the low 12 bits of the word at the address field. This read takes place in slot 3, so the instruction length does not change.
- R5: Opcode 0 sets AC to AC AND M[ea]. Opcode 2 sets AC to M[ea].
- R6: Opcode 1 sets AC to the low 16 bits of AC + M[ea] and E to the carry out. No other opcode changes E.
- R7: Opcode 3 writes AC into M[ea]. Opcode 4 sets PC to ea.
- R8: Opcode 5 writes the zero-extended return PC into M[ea] and continues at ea + 1.
- R9: Opcode 6 writes M[ea] + 1 back to M[ea] and skips the next word when the new value is 0.
- R10: Opcode 7 raises rr_start for exactly one cycle in slot 3, with rr_code equal to instruction bits 11:0. The counter stays at 3 until rr_done is high, then goes to 0.
- R11: rr_done together with rr_halt clears run. From then on PC, AC, E and the slot counter never change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Memory load strobe, effective only in reset |
| ld_addr | input | 12 | Memory load address |
| ld_data | input | 16 | Memory load word |
| rr_done | input | 1 | Register-operation unit finished |
| rr_halt | input | 1 | With rr_done: stop the machine |
| rr_start | output | 1 | One-cycle request to the register-operation unit |
| rr_code | output | 12 | Low instruction bits for the register-operation unit |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| run_o | output | 1 | Run flag, 1 while running |
| sc_o | output | 4 | Slot counter |

## Verification
Two programs are run against a behavioural instruction-level model in the bench. The slot counter is compared on every clock, and the architectural state is compared at every instruction boundary. The first program uses direct addressing, a taken jump, a call whose return slot is later loaded, a wrapping increment-and-skip, and an add with and without carry. These separate a wrong slot length from a wrong result. The second program uses indirect addressing on store, call and increment, and an add that produces zero with carry. Register-operation answers come after one cycle in the first program and three cycles in the second, which shows whether the counter holds in slot 3 for the actual wait.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Opcode field, instruction bits 14:12
    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_RRF = 3'd7
    } op_e;

    // Number of timing slots any script uses (T0..T6)
    localparam int NSLOT = 7;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/acc_tdec.sv
module acc_tdec #(
    parameter int SC_W = 4,
    parameter int N    = 7
) (
    input  logic [SC_W-1:0] sc,
    output logic [N-1:0]    t
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        assign t[g] = (sc == SC_W'(g));
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          cout
);
    always_comb begin
        cout = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_ADD:  {cout, res} = {1'b0, a} + {1'b0, b};
            OP_LDA:  res = b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = DW - 4,
    parameter int SC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_addr,
    input  logic [DW-1:0]   ld_data,
    input  logic            rr_done,
    input  logic            rr_halt,
    output logic            rr_start,
    output logic [AW-1:0]   rr_code,
    output logic [AW-1:0]   pc_o,
    output logic [DW-1:0]   ac_o,
    output logic            e_o,
    output logic            run_o,
    output logic [SC_W-1:0] sc_o
);
    localparam logic [AW-1:0]   A_ONE  = AW'(1);
    localparam logic [DW-1:0]   D_ONE  = DW'(1);
    localparam logic [SC_W-1:0] SC_ONE = SC_W'(1);
    localparam int              OPC_HI = DW - 2;

    typedef struct packed {
        logic [AW-1:0]   pc;
        logic [AW-1:0]   ar;
        logic [DW-1:0]   ir;
        logic [DW-1:0]   dr;
        logic [DW-1:0]   ac;
        logic            e;
        logic            i;
        logic            s;
        logic            wt;
        logic [SC_W-1:0] sc;
    } regs_t;

    regs_t r_q, r_d;

    logic [DW-1:0]   mrd;
    logic [NSLOT-1:0] ts;
    logic [DW-1:0]   alu_res;
    logic            alu_c;
    logic            core_we;
    logic [DW-1:0]   core_wdata;
    logic            start_d;
    op_e             op;

    logic            mem_we;
    logic [AW-1:0]   mem_waddr;
    logic [DW-1:0]   mem_wdata;

    assign op = op_e'(r_q.ir[OPC_HI -: 3]);

    // The load port owns the memory write side only while reset is held
    assign mem_we    = rst_n ? core_we    : ld_en;
    assign mem_waddr = rst_n ? r_q.ar     : ld_addr;
    assign mem_wdata = rst_n ? core_wdata : ld_data;

    acc_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (r_q.ar),
        .rdata (mrd)
    );

    acc_tdec #(.SC_W(SC_W), .N(NSLOT)) u_tdec (
        .sc (r_q.sc),
        .t  (ts)
    );

    acc_alu #(.DW(DW)) u_alu (
        .op   (op),
        .a    (r_q.ac),
        .b    (r_q.dr),
        .res  (alu_res),
        .cout (alu_c)
    );

    always_comb begin
        r_d        = r_q;
        core_we    = 1'b0;
        core_wdata = '0;
        start_d    = 1'b0;
        if (r_q.s) begin
            r_d.sc = r_q.sc + SC_ONE;
            // fetch
            if (ts[0]) r_d.ar = r_q.pc;
            if (ts[1]) begin
                r_d.ir = mrd;
                r_d.pc = r_q.pc + A_ONE;
            end
            // decode
            if (ts[2]) begin
                r_d.ar = r_q.ir[AW-1:0];
                r_d.i  = r_q.ir[DW-1];
            end
            // indirection or register-operation handshake
            if (ts[3]) begin
                if (op == OP_RRF) begin
                    r_d.sc = r_q.sc;
                    if (!r_q.wt) begin
                        start_d = 1'b1;
                        r_d.wt  = 1'b1;
                    end else if (rr_done) begin
                        r_d.wt = 1'b0;
                        r_d.sc = '0;
                        if (rr_halt) r_d.s = 1'b0;
                    end
                end else if (r_q.i) begin
                    r_d.ar = mrd[AW-1:0];
                end
            end
            if (ts[4]) begin
                case (op)
                    OP_AND, OP_ADD, OP_LDA, OP_ISZ: r_d.dr = mrd;
                    OP_STA: begin
                        core_we    = 1'b1;
                        core_wdata = r_q.ac;
                        r_d.sc     = '0;
                    end
                    OP_BUN: begin
                        r_d.pc = r_q.ar;
                        r_d.sc = '0;
                    end
                    OP_BSA: begin
                        core_we    = 1'b1;
                        core_wdata = {{(DW-AW){1'b0}}, r_q.pc};
                        r_d.ar     = r_q.ar + A_ONE;
                    end
                    default: ;
                endcase
            end
            if (ts[5]) begin
                case (op)
                    OP_AND, OP_LDA: begin
                        r_d.ac = alu_res;
                        r_d.sc = '0;
                    end
                    OP_ADD: begin
                        r_d.ac = alu_res;
                        r_d.e  = alu_c;
                        r_d.sc = '0;
                    end
                    OP_BSA: begin
                        r_d.pc = r_q.ar;
                        r_d.sc = '0;
                    end
                    OP_ISZ: r_d.dr = r_q.dr + D_ONE;
                    default: ;
                endcase
            end
            if (ts[6]) begin
                core_we    = 1'b1;
                core_wdata = r_q.dr;
                if (r_q.dr == '0) r_d.pc = r_q.pc + A_ONE;
                r_d.sc = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= '0;
            r_q.s <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rr_start = start_d;
    assign rr_code  = r_q.ir[AW-1:0];
    assign pc_o     = r_q.pc;
    assign ac_o     = r_q.ac;
    assign e_o      = r_q.e;
    assign run_o    = r_q.s;
    assign sc_o     = r_q.sc;

    // Slot counter stays inside the scripted range
    p_sc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sc < SC_W'(NSLOT));

    // Fetch advances PC by one
    p_fetch_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.s && r_q.sc == SC_ONE) |=> (r_q.pc == $past(r_q.pc) + A_ONE));

    // Start is a single-cycle pulse
    p_start_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rr_start |=> !rr_start);

    // Counter holds while the register-operation unit is busy
    p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.s && r_q.wt && !rr_done) |=> $stable(r_q.sc));

    // A halted machine is frozen
    p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.s |=> (!r_q.s && $stable(r_q.pc) && $stable(r_q.ac)
                    && $stable(r_q.e) && r_q.sc == '0));
endmodule

// File: tb/acc_seq_core_bench.sv
module acc_seq_core_bench;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int SCW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n, ld_en, rr_done, rr_halt;
    logic [AW-1:0]  ld_addr;
    logic [DW-1:0]  ld_data;
    logic           rr_start, e_o, run_o;
    logic [AW-1:0]  rr_code, pc_o;
    logic [DW-1:0]  ac_o;
    logic [SCW-1:0] sc_o;

    acc_seq_core u_acc_seq_core (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .rr_done(rr_done), .rr_halt(rr_halt),
        .rr_start(rr_start), .rr_code(rr_code), .pc_o(pc_o), .ac_o(ac_o),
        .e_o(e_o), .run_o(run_o), .sc_o(sc_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int rr_delay = 1;

    // behavioural instruction-level model
    logic [DW-1:0] m_mem [4096];
    logic [AW-1:0] m_pc;
    logic [DW-1:0] m_ac;
    logic          m_e;
    bit            m_halt;
    string         last_tag = "R3";

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load(logic [AW-1:0] a, logic [DW-1:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        m_mem[a] = d;
    endtask

    task automatic release_reset();
        // R1: reset values
        chk("R1", pc_o, 0); chk("R1", sc_o, 0); chk("R1", ac_o, 0);
        chk("R1", e_o, 0);  chk("R1", run_o, 1);
        m_pc = '0; m_ac = '0; m_e = 1'b0; m_halt = 0; last_tag = "R3";
        rst_n = 1'b1;
    endtask

    // one instruction of the model; returns slot count and rr flag
    task automatic model_step(output int len, output bit is_rr,
                              output logic [AW-1:0] code);
        logic [DW-1:0] ir, v;
        logic [AW-1:0] ea;
        logic [16:0]   sum;
        logic [2:0]    op;
        bit            ind;
        ir = m_mem[m_pc];
        m_pc = m_pc + 1'b1;
        op = ir[14:12];
        ea = ir[11:0];
        code = ir[11:0];
        is_rr = (op == 3'd7);
        ind = 0;
        if (!is_rr && ir[15]) begin
            ea = m_mem[ea][11:0];
            ind = 1;
        end
        case (op)
            3'd0: begin m_ac = m_ac & m_mem[ea]; len = 6; last_tag = "R5"; end
            3'd1: begin
                sum = {1'b0, m_ac} + {1'b0, m_mem[ea]};
                m_ac = sum[15:0]; m_e = sum[16]; len = 6; last_tag = "R6";
            end
            3'd2: begin m_ac = m_mem[ea]; len = 6; last_tag = "R5"; end
            3'd3: begin m_mem[ea] = m_ac; len = 5; last_tag = "R7"; end
            3'd4: begin m_pc = ea; len = 5; last_tag = "R7"; end
            3'd5: begin
                m_mem[ea] = {4'h0, m_pc}; m_pc = ea + 1'b1; len = 6; last_tag = "R8";
            end
            3'd6: begin
                v = m_mem[ea] + 1'b1; m_mem[ea] = v;
                if (v == 16'h0000) m_pc = m_pc + 1'b1;
                len = 7; last_tag = "R9";
            end
            default: begin
                len = 4 + rr_delay; last_tag = "R10";
                if (ir[11:0] == 12'h001) m_halt = 1;
            end
        endcase
        if (ind) last_tag = "R4";
    endtask

    task automatic run_prog(int max_instr);
        for (int n = 0; n < max_instr && !m_halt; n++) begin
            int len;
            bit is_rr;
            logic [AW-1:0] code;
            chk(last_tag, pc_o, m_pc);
            chk(last_tag, ac_o, m_ac);
            chk("R6", e_o, m_e);
            chk("R11", run_o, 1);
            model_step(len, is_rr, code);
            for (int k = 0; k < len; k++) begin
                chk("R2", sc_o, (k < 3) ? k : (is_rr ? 3 : k));
                chk("R10", rr_start, (is_rr && k == 3) ? 1 : 0);
                if (is_rr && k == 3) chk("R10", rr_code, code);
                @(negedge clk);
            end
        end
        // R11: stopped and frozen
        chk("R11", run_o, 0);
        for (int k = 0; k < 4; k++) begin
            chk("R11", sc_o, 0);
            chk("R11", pc_o, m_pc);
            chk("R11", ac_o, m_ac);
            chk("R11", e_o, m_e);
            @(negedge clk);
        end
    endtask

    // register-operation responder
    initial begin
        logic [AW-1:0] c;
        rr_done = 1'b0; rr_halt = 1'b0;
        forever begin
            @(negedge clk);
            if (rr_start === 1'b1) begin
                c = rr_code;
                repeat (rr_delay) @(negedge clk);
                rr_halt = (c == 12'h001);
                rr_done = 1'b1;
                @(negedge clk);
                rr_done = 1'b0;
                rr_halt = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 4096; a++) m_mem[a] = '0;
        rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (2) @(negedge clk);

        // program 1: direct addressing, jump, call, skip, one-cycle answers
        load(12'h000, 16'h2010);  // load 010
        load(12'h001, 16'h1011);  // add 011, no carry
        load(12'h002, 16'h0012);  // and 012
        load(12'h003, 16'h3013);  // store 013
        load(12'h004, 16'h1014);  // add 014, carry
        load(12'h005, 16'h4008);  // jump 008
        load(12'h006, 16'h7001);  // skipped halt
        load(12'h008, 16'h5020);  // call 020
        load(12'h009, 16'h7001);  // halt
        load(12'h020, 16'h0000);
        load(12'h021, 16'h6030);  // increment wraps to 0, skip
        load(12'h022, 16'h7001);  // skipped halt
        load(12'h023, 16'hA031);  // load indirect via 031
        load(12'h024, 16'h6032);  // increment, no skip
        load(12'h025, 16'h7800);  // register operation, no halt
        load(12'h026, 16'h2020);  // load return slot
        load(12'h027, 16'hC033);  // jump indirect via 033
        load(12'h010, 16'h8F0F);
        load(12'h011, 16'h0123);
        load(12'h012, 16'hF0F0);
        load(12'h014, 16'h7000);
        load(12'h030, 16'hFFFF);
        load(12'h031, 16'h0013);
        load(12'h032, 16'h0005);
        load(12'h033, 16'h0009);
        rr_delay = 1;
        release_reset();
        run_prog(40);

        // program 2: indirect store, call, increment; three-cycle answers
        rst_n = 1'b0;
        @(negedge clk);
        load(12'h000, 16'hE040);  // increment indirect
        load(12'h001, 16'h2041);  // load 041
        load(12'h002, 16'hD042);  // call indirect
        load(12'h051, 16'h7020);  // register operation
        load(12'h052, 16'hB043);  // store indirect
        load(12'h053, 16'h2060);  // load 060
        load(12'h054, 16'h1044);  // add to zero with carry
        load(12'h055, 16'h0045);  // and with zero
        load(12'h056, 16'h7001);  // halt
        load(12'h040, 16'h0041);
        load(12'h041, 16'h0007);
        load(12'h042, 16'h0050);
        load(12'h043, 16'h0060);
        load(12'h044, 16'hFFF8);
        load(12'h045, 16'h0000);
        rr_delay = 3;
        release_reset();
        run_prog(40);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule